// File: doc/BRIEF.md
# Converter Control Register Serial Port

This block is the serial control port of a two-channel 14-bit converter. A host reaches a small register file through a four-wire serial link. Each access is a fixed frame of sixteen clock bits opened and closed by an active-low chip select. The registers set what each channel's 14-bit output bus carries. The choices are the live conversion word, a fixed built-in test word, or a test word assembled from two user registers. The registers also hold the power-down request for each channel.

A mode input decides who controls the converter. When it is high, the register contents govern the outputs and the direct control pins are ignored. When it is low, the serial port is dead and the direct pins govern the outputs. The serial lines are oversampled in the system clock domain through synchronizer stages. The host's serial clock must therefore run at no more than about one eighth of the system clock.

Top module: `adc_ctrl_spi`

## Requirements
- R1: After reset the control register reads 0x08 and both user pattern registers read 0x00. Both output buses then carry the live conversion words and both power-down outputs are low.
- R2: A frame is 16 bits, most significant bit first, and each bit is sampled on a rising serial clock. The bits are, in order: a direction bit (0 = write, 1 = read), a 7-bit address, and an 8-bit data byte. A write takes effect on the 16th rising edge. Address 0x00 is the control register, 0x01 holds the high six pattern bits and 0x02 holds the low eight pattern bits.
- R3: If chip select rises before the 16th rising edge, no register changes.
- R4: During a read, the serial output carries the addressed register, most significant bit first. Each data bit is updated on a falling edge, so that it is valid at rising edges 9 through 16. The serial output is 0 while chip select is high.
- R5: A write to any unmapped address changes no register, and a read of an unmapped address returns 0x00.
- R6: Only bits 5:0 of the high pattern register are stored. Bits 7:6 always read as zero.
- R7: When control bits 7:6 are 00, each output bus carries its channel's conversion word one system clock later.
- R8: When control bit 7 is 1, both buses carry the fixed word 10100110001110 (0x298E).
- R9: When control bits 7:6 are 01, both buses carry the 14-bit word formed by high-register bits 5:0 above low-register bits 7:0.
- R10: With the enable input low, the following hold. A whole frame changes no register and the serial output stays 0. The power-down outputs follow their pins one clock later. The test pin, when high, puts the fixed word on both buses; when low, the buses pass the conversion words.
- R11: With the enable input high, the power-down pins and the test pin have no effect. Channel A power-down follows control bit 1 and channel B power-down follows control bit 0, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_en_i | input | 1 | 1: registers govern, 0: direct pins govern |
| spi_cs_ni | input | 1 | Serial chip select, active low |
| spi_sclk_i | input | 1 | Serial clock |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out |
| pin_pd_a_i | input | 1 | Direct power-down request, channel A |
| pin_pd_b_i | input | 1 | Direct power-down request, channel B |
| pin_test_i | input | 1 | Direct fixed-test-word request |
| conv_a_i | input | 14 | Conversion word, channel A |
| conv_b_i | input | 14 | Conversion word, channel B |
| data_a_o | output | 14 | Output bus, channel A |
| data_b_o | output | 14 | Output bus, channel B |
| pd_a_o | output | 1 | Power-down, channel A |
| pd_b_o | output | 1 | Power-down, channel B |

## Verification
Two functions can act in the same cycle. One is a complete serial write arriving at the control register. The other is the direct pins contending for the same outputs. To provoke this, the bench runs a full write frame with the enable input low, while the power-down and test pins are set opposite to what the write would select. The outputs are judged against the pins on every clock. After the enable input is raised again, a readback must return the old control value. Random writes and readbacks are also mixed in, and after each one the bench compares both buses against the selected source.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_USER = 2'b01,
    MODE_FIX0 = 2'b10,
    MODE_FIX1 = 2'b11
  } mode_t;

  localparam int ADR_CTRL    = 'h00;
  localparam int ADR_UPAT_HI = 'h01;
  localparam int ADR_UPAT_LO = 'h02;
  localparam int CTRL_RST    = 'h08;
  localparam int FIX_WORD    = 'h298E;  // 10100110001110
endpackage

// File: rtl/adc_spi_shift.sv
module adc_spi_shift #(
  parameter int ADDR_W      = 7,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              miso_o
);
  localparam int FRAME_W = 1 + ADDR_W + REG_W;
  localparam int HDR_W   = 1 + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int SH_W    = (ADDR_W > REG_W - 1) ? ADDR_W : REG_W - 1;

  logic [SYNC_STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk_i};
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_ni};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi_i};
      sclk_d <= sclk_s[SYNC_STAGES-1];
    end
  end

  logic sclk_now, mosi_now, rise, fall, sel;
  assign sclk_now = sclk_s[SYNC_STAGES-1];
  assign mosi_now = mosi_s[SYNC_STAGES-1];
  assign rise     = sclk_now & ~sclk_d;
  assign fall     = ~sclk_now & sclk_d;
  assign sel      = ~cs_s[SYNC_STAGES-1] & en_i;

  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q;
  logic              rw_q, load_q, wr_q, miso_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  rd_sh_q, wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      load_q    <= 1'b0;
      wr_q      <= 1'b0;
      miso_q    <= 1'b0;
      addr_q    <= '0;
      rd_sh_q   <= '0;
      wr_data_q <= '0;
    end else begin
      wr_q   <= 1'b0;
      load_q <= 1'b0;
      if (!sel) begin
        cnt_q  <= '0;
        rw_q   <= 1'b0;
        miso_q <= 1'b0;
      end else begin
        if (rise && cnt_q < CNT_W'(FRAME_W)) begin
          sh_q  <= {sh_q[SH_W-2:0], mosi_now};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            rw_q   <= sh_q[ADDR_W-1];
            addr_q <= {sh_q[ADDR_W-2:0], mosi_now};
            load_q <= 1'b1;
          end
          if (cnt_q == CNT_W'(FRAME_W - 1)) begin
            wr_q      <= ~rw_q;
            wr_data_q <= {sh_q[REG_W-2:0], mosi_now};
          end
        end
        if (load_q) rd_sh_q <= rd_data_i;
        // data bits leave on falling edges 8..15 so they are stable at rises 9..16
        if (fall && rw_q && cnt_q >= CNT_W'(HDR_W) && cnt_q < CNT_W'(FRAME_W)) begin
          miso_q  <= rd_sh_q[REG_W-1];
          rd_sh_q <= {rd_sh_q[REG_W-2:0], 1'b0};
        end
      end
    end
  end

  assign addr_o    = addr_q;
  assign wr_o      = wr_q;
  assign wr_data_o = wr_data_q;
  assign miso_o    = miso_q;
endmodule

// File: rtl/adc_spi_regs.sv
module adc_spi_regs
  import adc_spi_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int REG_W  = 8,
  parameter int DATA_W = 14,
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output mode_t             mode_o,
  output logic [NUM_CH-1:0] pd_o,
  output logic [DATA_W-1:0] upat_o
);
  localparam int HI_W = DATA_W - REG_W;

  logic [REG_W-1:0] ctrl_q, lo_q;
  logic [HI_W-1:0]  hi_q;
  logic hit_ctrl, hit_hi, hit_lo;

  assign hit_ctrl = addr_i == ADDR_W'(ADR_CTRL);
  assign hit_hi   = addr_i == ADDR_W'(ADR_UPAT_HI);
  assign hit_lo   = addr_i == ADDR_W'(ADR_UPAT_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= REG_W'(CTRL_RST);
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (wr_i) begin
      if (hit_ctrl) ctrl_q <= wr_data_i;
      if (hit_hi)   hi_q   <= wr_data_i[HI_W-1:0];
      if (hit_lo)   lo_q   <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (hit_ctrl)    rd_data_o = ctrl_q;
    else if (hit_hi) rd_data_o = REG_W'(hi_q);
    else if (hit_lo) rd_data_o = lo_q;
  end

  assign mode_o = mode_t'(ctrl_q[REG_W-1 -: 2]);
  assign upat_o = {hi_q, lo_q};

  // channel A takes bit NUM_CH-1, last channel takes bit 0
  for (genvar c = 0; c < NUM_CH; c++) begin : g_pd
    assign pd_o[c] = ctrl_q[NUM_CH-1-c];
  end
endmodule

// File: rtl/adc_spi_outsel.sv
module adc_spi_outsel
  import adc_spi_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int NUM_CH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     spi_en_i,
  input  mode_t                    mode_i,
  input  logic                     pin_test_i,
  input  logic [DATA_W-1:0]        upat_i,
  input  logic [NUM_CH*DATA_W-1:0] conv_i,
  input  logic [NUM_CH-1:0]        pin_pd_i,
  input  logic [NUM_CH-1:0]        reg_pd_i,
  output logic [NUM_CH*DATA_W-1:0] data_o,
  output logic [NUM_CH-1:0]        pd_o
);
  mode_t src;
  always_comb begin
    if (!spi_en_i) src = pin_test_i ? MODE_FIX0 : MODE_NORM;
    else           src = mode_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] dq;
    logic              pq;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dq <= '0;
        pq <= 1'b0;
      end else begin
        unique case (src)
          MODE_NORM: dq <= conv_i[c*DATA_W +: DATA_W];
          MODE_USER: dq <= upat_i;
          default:   dq <= DATA_W'(FIX_WORD);
        endcase
        pq <= spi_en_i ? reg_pd_i[c] : pin_pd_i[c];
      end
    end
    assign data_o[c*DATA_W +: DATA_W] = dq;
    assign pd_o[c] = pq;
  end
endmodule

// File: rtl/adc_ctrl_spi.sv
module adc_ctrl_spi
  import adc_spi_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int REG_W       = 8,
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_en_i,
  input  logic              spi_cs_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  input  logic              pin_pd_a_i,
  input  logic              pin_pd_b_i,
  input  logic              pin_test_i,
  input  logic [DATA_W-1:0] conv_a_i,
  input  logic [DATA_W-1:0] conv_b_i,
  output logic [DATA_W-1:0] data_a_o,
  output logic [DATA_W-1:0] data_b_o,
  output logic              pd_a_o,
  output logic              pd_b_o
);
  localparam int NUM_CH = 2;

  logic [ADDR_W-1:0]        addr;
  logic                     wr;
  logic [REG_W-1:0]         wr_data, rd_data;
  mode_t                    mode;
  logic [NUM_CH-1:0]        reg_pd, pd;
  logic [DATA_W-1:0]        upat;
  logic [NUM_CH*DATA_W-1:0] data;

  adc_spi_shift #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk_i, .rst_ni,
    .en_i      (spi_en_i),
    .cs_ni     (spi_cs_ni),
    .sclk_i    (spi_sclk_i),
    .mosi_i    (spi_mosi_i),
    .rd_data_i (rd_data),
    .addr_o    (addr),
    .wr_o      (wr),
    .wr_data_o (wr_data),
    .miso_o    (spi_miso_o)
  );

  adc_spi_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_regs (
    .clk_i, .rst_ni,
    .wr_i      (wr),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .mode_o    (mode),
    .pd_o      (reg_pd),
    .upat_o    (upat)
  );

  adc_spi_outsel #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_out (
    .clk_i, .rst_ni,
    .spi_en_i,
    .mode_i     (mode),
    .pin_test_i,
    .upat_i     (upat),
    .conv_i     ({conv_b_i, conv_a_i}),
    .pin_pd_i   ({pin_pd_b_i, pin_pd_a_i}),
    .reg_pd_i   (reg_pd),
    .data_o     (data),
    .pd_o       (pd)
  );

  assign data_a_o = data[DATA_W-1:0];
  assign data_b_o = data[NUM_CH*DATA_W-1 -: DATA_W];
  assign pd_a_o   = pd[0];
  assign pd_b_o   = pd[1];
endmodule

// File: rtl/adc_ctrl_spi_chk.sv
module adc_ctrl_spi_chk
  import adc_spi_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spi_en_i,
  input logic              spi_cs_ni,
  input logic              spi_miso_o,
  input logic              pin_pd_a_i,
  input logic              pin_pd_b_i,
  input logic              pin_test_i,
  input logic [DATA_W-1:0] conv_a_i,
  input logic [DATA_W-1:0] conv_b_i,
  input logic [DATA_W-1:0] data_a_o,
  input logic [DATA_W-1:0] data_b_o,
  input logic              pd_a_o,
  input logic              pd_b_o,
  input mode_t             mode,
  input logic [1:0]        reg_pd
);
  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  assert_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(spi_en_i) && $past(mode) == MODE_NORM
      |-> data_a_o == $past(conv_a_i) && data_b_o == $past(conv_b_i));

  assert_fixed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(spi_en_i) && $past(mode[1])
      |-> data_a_o == DATA_W'(FIX_WORD) && data_b_o == DATA_W'(FIX_WORD));

  assert_pin_pd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && !$past(spi_en_i)
      |-> pd_a_o == $past(pin_pd_a_i) && pd_b_o == $past(pin_pd_b_i));

  assert_pin_test_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && !$past(spi_en_i) && $past(pin_test_i)
      |-> data_a_o == DATA_W'(FIX_WORD));

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && !$past(spi_en_i) |-> !spi_miso_o);

  assert_reg_pd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(spi_en_i)
      |-> pd_a_o == $past(reg_pd[0]) && pd_b_o == $past(reg_pd[1]));

  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(spi_cs_ni) && spi_cs_ni && $past(spi_cs_ni, 2)
      && $past(spi_cs_ni, 3) |-> !spi_miso_o);
endmodule

bind adc_ctrl_spi adc_ctrl_spi_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .spi_en_i, .spi_cs_ni, .spi_miso_o,
  .pin_pd_a_i, .pin_pd_b_i, .pin_test_i,
  .conv_a_i, .conv_b_i, .data_a_o, .data_b_o, .pd_a_o, .pd_b_o,
  .mode   (mode),
  .reg_pd (reg_pd)
);

// File: tb/adc_ctrl_spi_test.sv
`timescale 1ns/1ps
module adc_ctrl_spi_test;
  localparam logic [13:0] FIX = 14'b10100110001110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_en = 1'b1, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic pin_pd_a = 1'b0, pin_pd_b = 1'b0, pin_test = 1'b0;
  logic [13:0] conv_a = '0, conv_b = '0;
  logic miso, pd_a, pd_b;
  logic [13:0] data_a, data_b;

  int total = 0, bad = 0;
  logic [7:0] ctrl_m = 8'h08, hi_m = 8'h00, lo_m = 8'h00;

  always #4 clk = ~clk;

  adc_ctrl_spi uut (
    .clk_i(clk), .rst_ni(rst_n), .spi_en_i(spi_en), .spi_cs_ni(cs_n),
    .spi_sclk_i(sclk), .spi_mosi_i(mosi), .spi_miso_o(miso),
    .pin_pd_a_i(pin_pd_a), .pin_pd_b_i(pin_pd_b), .pin_test_i(pin_test),
    .conv_a_i(conv_a), .conv_b_i(conv_b), .data_a_o(data_a), .data_b_o(data_b),
    .pd_a_o(pd_a), .pd_b_o(pd_b)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, output logic [7:0] rd);
    rd = '0;
    cs_n = 1'b0;
    wait_n(4);
    for (int i = 15; i > 15 - nbits; i--) begin
      mosi = w[i];
      wait_n(4);
      if (i < 8) rd[i] = miso;
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
    end
    wait_n(4);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_n(4);
  endtask

  task automatic spi_wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    frame({1'b0, a, d}, 16, dummy);
  endtask

  task automatic spi_rd(input logic [6:0] a, output logic [7:0] d);
    frame({1'b1, a, 8'h00}, 16, d);
  endtask

  function automatic void model_wr(logic [6:0] a, logic [7:0] d);
    case (a)
      7'h00: ctrl_m = d;
      7'h01: hi_m = {2'b00, d[5:0]};
      7'h02: lo_m = d;
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] model_rd(logic [6:0] a);
    case (a)
      7'h00: return ctrl_m;
      7'h01: return hi_m;
      7'h02: return lo_m;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [13:0] exp_data(logic [13:0] conv);
    if (!spi_en) return pin_test ? FIX : conv;
    case (ctrl_m[7:6])
      2'b00:   return conv;
      2'b01:   return {hi_m[5:0], lo_m};
      default: return FIX;
    endcase
  endfunction

  task automatic chk_out(input string tag);
    conv_a = 14'($urandom);
    conv_b = 14'($urandom);
    wait_n(2);
    chk({tag, " data_a"}, 32'(data_a), 32'(exp_data(conv_a)));
    chk({tag, " data_b"}, 32'(data_b), 32'(exp_data(conv_b)));
    chk({tag, " pd_a"}, 32'(pd_a), 32'(spi_en ? ctrl_m[1] : pin_pd_a));
    chk({tag, " pd_b"}, 32'(pd_b), 32'(spi_en ? ctrl_m[0] : pin_pd_b));
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a);
    logic [7:0] v;
    spi_rd(a, v);
    chk(tag, 32'(v), 32'(model_rd(a)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] w;
    void'($urandom(32'd20240611));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    chk_out("R1 reset outputs");
    rd_chk("R1 ctrl reset", 7'h00);
    rd_chk("R1 hi reset", 7'h01);
    rd_chk("R1 lo reset", 7'h02);
    chk("R4 miso idle", 32'(miso), 32'd0);

    spi_wr(7'h00, 8'h80); model_wr(7'h00, 8'h80);
    chk_out("R8 fixed word");
    rd_chk("R2 ctrl readback", 7'h00);

    spi_wr(7'h01, 8'hFF); model_wr(7'h01, 8'hFF);
    spi_wr(7'h02, 8'h5A); model_wr(7'h02, 8'h5A);
    rd_chk("R6 reserved hi bits", 7'h01);
    rd_chk("R4 lo readback", 7'h02);
    spi_wr(7'h00, 8'h40); model_wr(7'h00, 8'h40);
    chk_out("R9 user word");
    spi_wr(7'h00, 8'hC0); model_wr(7'h00, 8'hC0);
    chk_out("R8 mode 11");
    spi_wr(7'h00, 8'h00); model_wr(7'h00, 8'h00);
    chk_out("R7 pass through");
    chk_out("R7 pass through again");

    frame({1'b0, 7'h00, 8'hC3}, 10, v);
    rd_chk("R3 abort at 10", 7'h00);
    frame({1'b0, 7'h00, 8'hC3}, 15, v);
    rd_chk("R3 abort at 15", 7'h00);
    chk_out("R3 outputs unchanged");

    spi_wr(7'h7F, 8'hFF); model_wr(7'h7F, 8'hFF);
    spi_wr(7'h03, 8'hFF); model_wr(7'h03, 8'hFF);
    rd_chk("R5 unmapped read 7F", 7'h7F);
    rd_chk("R5 unmapped read 03", 7'h03);
    rd_chk("R5 ctrl intact", 7'h00);
    rd_chk("R5 lo intact", 7'h02);

    spi_wr(7'h00, 8'h02); model_wr(7'h00, 8'h02);
    pin_pd_a = 1'b0; pin_pd_b = 1'b1; pin_test = 1'b1;
    chk_out("R11 pins ignored");

    spi_en = 1'b0;
    wait_n(2);
    chk_out("R10 pins govern");
    w = {1'b0, 7'h00, 8'h41};
    frame(w, 16, v);
    chk_out("R10 write while disabled");
    frame({1'b1, 7'h00, 8'h00}, 16, v);
    chk("R10 miso silent", 32'(v), 32'd0);
    pin_test = 1'b0; pin_pd_a = 1'b1; pin_pd_b = 1'b0;
    chk_out("R10 test pin low");
    spi_en = 1'b1;
    wait_n(2);
    rd_chk("R10 ctrl kept", 7'h00);
    chk_out("R11 back to registers");

    for (int k = 0; k < 24; k++) begin
      logic [6:0] a;
      logic [7:0] d;
      case ($urandom % 4)
        0: a = 7'h00;
        1: a = 7'h01;
        2: a = 7'h02;
        default: a = 7'($urandom);
      endcase
      d = 8'($urandom);
      pin_pd_a = 1'($urandom);
      pin_pd_b = 1'($urandom);
      pin_test = 1'($urandom);
      spi_wr(a, d); model_wr(a, d);
      rd_chk("R2 random readback", a);
      chk_out("R7 R9 R11 random outputs");
    end
    chk("R4 miso after frames", 32'(miso), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule